// File: doc/BRIEF.md
# Peripheral Handshake Strobe Generator

This block drives the second control line of one side of a parallel peripheral port once that line is configured as an output. It produces either a one-shot handshake strobe that tells the peripheral a transfer happened, or a fixed level that software programs. A parameter chooses the side. The read side pulls the line low after the processor reads the port's output register. The write side pulls it low after the processor writes that register.

A strobe ends in one of two ways. The first is the peripheral's active edge on the first control line. The second is timing derived from the bus enable clock, counted while the port is not selected. All inputs are single-cycle event pulses that a bus front end produces in the block's clock domain: enable rising and falling edges, data-register access pulses, and the already-qualified active edge of the first control line. The select state and three configuration bits are levels.

Top module: `hs_strobe_gen`

## Requirements
- R1: `c2_oe` equals `ctl_mode[2]`. While `ctl_mode[2]` is 0 the drive level `c2_out` is 1. After reset, with `ctl_mode` = 0, `c2_oe` is 0 and `c2_out` is 1.
- R2: Read side (`SIDE_B`=0), strobe modes (`ctl_mode[2:1]`=2'b10). A `rd_dat` pulse arms the block. On the next `e_fall` pulse in a later cycle, `c2_out` goes to 0 one clock after that pulse. `wr_dat` has no effect.
- R3: Write side (`SIDE_B`=1), strobe modes. A `wr_dat` pulse arms the block. On the next `e_rise` pulse in a later cycle, `c2_out` goes to 0 one clock after that pulse. `rd_dat` has no effect.
- R4: Peripheral restore (`ctl_mode[0]`=0). A low `c2_out` returns to 1 one clock after a `c1_act` pulse. On the write side this happens only if `flag_clr` is 1 in that cycle.
- R5: Read side, timed restore (`ctl_mode[0]`=1). A low `c2_out` returns to 1 one clock after an `e_fall` pulse seen with `sel`=0.
- R6: Write side, timed restore (`ctl_mode[0]`=1). While `c2_out` is low, an `e_fall` with `sel`=0 is remembered. The next `e_rise` after it returns `c2_out` to 1 one clock later.
- R7: Level mode (`ctl_mode[2:1]`=2'b11). `c2_out` equals `ctl_mode[0]` and follows its changes.
- R8: On entering a strobe mode, `c2_out` is 1. Leaving the strobe modes discards any armed or active strobe.
- R9: A low strobe stays low until its restore event. An access pulse with no following trigger edge leaves `c2_out` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_mode | input | 3 | {output select, level-mode select, mode/level bit} |
| sel | input | 1 | Port is selected during the current enable pulse |
| e_rise | input | 1 | Enable rising-edge event pulse |
| e_fall | input | 1 | Enable falling-edge event pulse |
| rd_dat | input | 1 | Processor read of output data register (pulse) |
| wr_dat | input | 1 | Processor write of output data register (pulse) |
| c1_act | input | 1 | Active edge seen on the first control line (pulse) |
| flag_clr | input | 1 | Primary interrupt flag currently clear |
| c2_oe | output | 1 | Output enable of the second control line |
| c2_out | output | 1 | Drive level of the second control line |

## Verification
A stuck or lost arm bit appears at the ports as a missing or spurious low on `c2_out`, one clock after the enable edge that should or should not have started the strobe. A wrong restore path leaves `c2_out` low past its restore event, or releases it early. This shows one clock after the `c1_act` or enable event concerned. A deselect tracker that fails to clear carries over into the next strobe. It ends that strobe at the first enable rise, where the strobe should have waited for a fresh deselected pulse. Random mode changes in the middle of a strobe check that state does not leak across modes.

// File: rtl/hs_strobe_pkg.sv
package hs_strobe_pkg;

    // Strobe sequencing state: access seen, strobe line pulled low
    typedef struct packed {
        logic arm;
        logic low;
    } strb_st_t;

    // Bit positions inside ctl_mode
    localparam int unsigned MODE_OUT_BIT = 2;
    localparam int unsigned MODE_LVL_BIT = 1;
    localparam int unsigned MODE_SEL_BIT = 0;
    localparam int unsigned MODE_W       = 3;

endpackage

// File: rtl/hs_evt_map.sv
module hs_evt_map #(
    parameter bit SIDE_B = 1'b0
) (
    input  logic e_mode,
    input  logic sel,
    input  logic e_rise,
    input  logic e_fall,
    input  logic rd_dat,
    input  logic wr_dat,
    input  logic c1_act,
    input  logic flag_clr,
    input  logic desel_q,
    output logic acc_ev,
    output logic trig_ev,
    output logic rst_ev
);

    generate
        if (SIDE_B) begin : g_write_side
            // write strobe: armed by writes, fires on enable rise
            assign acc_ev  = wr_dat;
            assign trig_ev = e_rise;
            assign rst_ev  = e_mode ? (e_rise & desel_q) : (c1_act & flag_clr);
            logic unused_b;
            assign unused_b = rd_dat ^ e_fall ^ sel;
        end else begin : g_read_side
            // read strobe: armed by reads, fires on enable fall
            assign acc_ev  = rd_dat;
            assign trig_ev = e_fall;
            assign rst_ev  = e_mode ? (e_fall & ~sel) : c1_act;
            logic unused_a;
            assign unused_a = wr_dat ^ e_rise ^ flag_clr ^ desel_q;
        end
    endgenerate

endmodule

// File: rtl/hs_desel_track.sv
module hs_desel_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic low_q,
    input  logic rst_ev,
    input  logic e_fall,
    input  logic sel,
    output logic desel_q
);

    logic desel_d;

    // Remember a completed deselected enable pulse while the strobe is low
    always_comb begin
        desel_d = 1'b0;
        if (!clr && low_q && !rst_ev) begin
            desel_d = desel_q | (e_fall & ~sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) desel_q <= 1'b0;
        else        desel_q <= desel_d;
    end

endmodule

// File: rtl/hs_strobe_gen.sv
module hs_strobe_gen
    import hs_strobe_pkg::*;
#(
    parameter bit SIDE_B = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] ctl_mode,
    input  logic              sel,
    input  logic              e_rise,
    input  logic              e_fall,
    input  logic              rd_dat,
    input  logic              wr_dat,
    input  logic              c1_act,
    input  logic              flag_clr,
    output logic              c2_oe,
    output logic              c2_out
);

    strb_st_t st_d, st_q;
    logic     strobe_mode, e_mode;
    logic     acc_ev, trig_ev, rst_ev, desel_q;

    assign strobe_mode = ctl_mode[MODE_OUT_BIT] & ~ctl_mode[MODE_LVL_BIT];
    assign e_mode      = ctl_mode[MODE_SEL_BIT];

    hs_evt_map #(.SIDE_B(SIDE_B)) u_map (
        .e_mode  (e_mode),
        .sel     (sel),
        .e_rise  (e_rise),
        .e_fall  (e_fall),
        .rd_dat  (rd_dat),
        .wr_dat  (wr_dat),
        .c1_act  (c1_act),
        .flag_clr(flag_clr),
        .desel_q (desel_q),
        .acc_ev  (acc_ev),
        .trig_ev (trig_ev),
        .rst_ev  (rst_ev)
    );

    generate
        if (SIDE_B) begin : g_track
            hs_desel_track u_track (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (~strobe_mode | ~e_mode),
                .low_q  (st_q.low),
                .rst_ev (rst_ev),
                .e_fall (e_fall),
                .sel    (sel),
                .desel_q(desel_q)
            );
        end else begin : g_no_track
            assign desel_q = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!strobe_mode) begin
            st_d = '0;
        end else begin
            st_d.arm = (st_q.arm & ~trig_ev) | acc_ev;
            if (st_q.low && rst_ev)   st_d.low = 1'b0;
            if (st_q.arm && trig_ev)  st_d.low = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign c2_oe  = ctl_mode[MODE_OUT_BIT];
    assign c2_out = ~ctl_mode[MODE_OUT_BIT] |
                    (ctl_mode[MODE_LVL_BIT] ? ctl_mode[MODE_SEL_BIT] : ~st_q.low);

    // A strobe start needs the side's trigger edge in the prior cycle
    AST_FALL_HAS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_mode && $past(strobe_mode) && $fell(c2_out)) |-> $past(trig_ev)); // R2

    // Peripheral restore only on a qualified first-line edge
    AST_C1_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_mode && $past(strobe_mode) && !e_mode && $past(!e_mode) && $rose(c2_out))
        |-> $past(c1_act)); // R4

    // Timed restore only on the enable edge of the side
    AST_TIMED_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_mode && $past(strobe_mode) && e_mode && $past(e_mode) && $rose(c2_out))
        |-> $past(SIDE_B ? e_rise : (e_fall & ~sel))); // R5

    // Low strobe holds without a restore event
    AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_mode && $past(strobe_mode) && $past(!c2_out) && $past(!rst_ev))
        |-> !c2_out); // R9

    // Output enable drops low-level drive: idle high when not an output
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !c2_oe |-> c2_out); // R1

endmodule

// File: tb/tb_hs_strobe_gen.sv
module tb_hs_strobe_gen;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ctl_mode = 3'b000;
    logic       sel = 1'b1, e_rise = 1'b0, e_fall = 1'b0;
    logic       rd_dat = 1'b0, wr_dat = 1'b0, c1_act = 1'b0, flag_clr = 1'b0;
    logic       oe_a, out_a, oe_b, out_b;

    int checks = 0;
    int errors = 0;

    // reference state per side: armed, low, deselected pulse seen
    bit ra_arm, ra_low, rb_arm, rb_low, rb_dsl;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_strobe_gen #(.SIDE_B(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .sel(sel),
        .e_rise(e_rise), .e_fall(e_fall), .rd_dat(rd_dat), .wr_dat(wr_dat),
        .c1_act(c1_act), .flag_clr(flag_clr), .c2_oe(oe_a), .c2_out(out_a));

    hs_strobe_gen #(.SIDE_B(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .sel(sel),
        .e_rise(e_rise), .e_fall(e_fall), .rd_dat(rd_dat), .wr_dat(wr_dat),
        .c1_act(c1_act), .flag_clr(flag_clr), .c2_oe(oe_b), .c2_out(out_b));

    function automatic bit exp_level(input logic [2:0] m, input bit low);
        if (!m[2]) return 1'b1;       // R1
        if (m[1])  return m[0];       // R7
        return !low;                  // R2..R6
    endfunction

    function automatic string tag_of(input logic [2:0] m, input bit side_b);
        if (!m[2]) return "R1";
        if (m[1])  return "R7";
        return side_b ? "R3/R4/R6" : "R2/R4/R5";
    endfunction

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference update for one rising clock edge with current inputs
    task automatic ref_step();
        bit strobe, tmode, ra_rst, rb_rst, nb_low, na_low;
        strobe = ctl_mode[2] && !ctl_mode[1];
        tmode  = ctl_mode[0];
        if (!rst_n || !strobe) begin
            ra_arm = 0; ra_low = 0; rb_arm = 0; rb_low = 0; rb_dsl = 0;
            return;
        end
        // read side
        ra_rst = tmode ? (e_fall && !sel) : c1_act;
        na_low = ra_low;
        if (ra_low && ra_rst) na_low = 0;
        if (ra_arm && e_fall) na_low = 1;
        ra_arm = (ra_arm && !e_fall) || rd_dat;
        ra_low = na_low;
        // write side
        rb_rst = tmode ? (e_rise && rb_dsl) : (c1_act && flag_clr);
        nb_low = rb_low;
        if (rb_low && rb_rst) nb_low = 0;
        if (rb_arm && e_rise) nb_low = 1;
        rb_dsl = tmode && rb_low && !rb_rst && (rb_dsl || (e_fall && !sel));
        rb_arm = (rb_arm && !e_rise) || wr_dat;
        rb_low = nb_low;
    endtask

    // one cycle: drive at negedge, advance model, compare after the edge
    task automatic cyc(input logic [2:0] m, input bit s, input bit er, input bit ef,
                       input bit rd, input bit wr, input bit c1, input bit fc);
        ctl_mode = m; sel = s; e_rise = er; e_fall = ef;
        rd_dat = rd; wr_dat = wr; c1_act = c1; flag_clr = fc;
        @(posedge clk);
        ref_step();
        @(negedge clk);
        check({tag_of(ctl_mode, 0), " oe"}, oe_a, ctl_mode[2]);
        check({tag_of(ctl_mode, 0), " A"}, out_a, exp_level(ctl_mode, ra_low));
        check({tag_of(ctl_mode, 1), " B"}, out_b, exp_level(ctl_mode, rb_low));
    endtask

    task automatic idle(input logic [2:0] m, input int n);
        for (int i = 0; i < n; i++) cyc(m, 1, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        process::self().srandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 reset oe", oe_a, 1'b0);
        check("R1 reset out", out_a, 1'b1);
        check("R1 reset out B", out_b, 1'b1);
        rst_n = 1'b1;
        idle(3'b000, 2);

        // R8: entering strobe mode idles high
        idle(3'b100, 1);
        check("R8 idle A", out_a, 1'b1);
        check("R8 idle B", out_b, 1'b1);

        // R2 / R3 / R9: access pulse alone keeps line high
        cyc(3'b100, 1, 0, 0, 1, 1, 0, 0);
        check("R9 armed A", out_a, 1'b1);
        check("R9 armed B", out_b, 1'b1);
        cyc(3'b100, 1, 0, 1, 0, 0, 0, 0);   // enable fall: A strobes
        check("R2 A low", out_a, 1'b0);
        check("R3 B still high on fall", out_b, 1'b1);
        cyc(3'b100, 1, 1, 0, 0, 0, 0, 0);   // enable rise: B strobes
        check("R3 B low", out_b, 1'b0);
        idle(3'b100, 3);
        check("R9 A holds", out_a, 1'b0);
        // R4: B waits for flag_clr
        cyc(3'b100, 1, 0, 0, 0, 0, 1, 0);
        check("R4 A restored", out_a, 1'b1);
        check("R4 B blocked by flag", out_b, 1'b0);
        cyc(3'b100, 1, 0, 0, 0, 0, 1, 1);
        check("R4 B restored", out_b, 1'b1);

        // R2: wr_dat ignored on read side, rd_dat ignored on write side
        cyc(3'b101, 1, 0, 0, 0, 1, 0, 0);
        cyc(3'b101, 1, 0, 1, 0, 0, 0, 0);
        check("R2 write ignored on A", out_a, 1'b1);
        cyc(3'b101, 1, 1, 0, 0, 0, 0, 0);
        check("R3 B low timed mode", out_b, 1'b0);
        // R6: selected pulse does not count; deselected one does
        cyc(3'b101, 1, 0, 1, 0, 0, 0, 0);
        cyc(3'b101, 1, 1, 0, 0, 0, 0, 0);
        check("R6 selected pulse ignored", out_b, 1'b0);
        cyc(3'b101, 0, 0, 1, 0, 0, 0, 0);
        check("R6 B low until rise", out_b, 1'b0);
        cyc(3'b101, 1, 1, 0, 0, 0, 0, 0);
        check("R6 B restored", out_b, 1'b1);
        // R5: read side timed restore
        cyc(3'b101, 1, 0, 0, 1, 0, 0, 0);
        cyc(3'b101, 1, 0, 1, 0, 0, 0, 0);
        check("R5 A low", out_a, 1'b0);
        cyc(3'b101, 1, 0, 1, 0, 0, 0, 0);
        check("R5 selected fall ignored", out_a, 1'b0);
        cyc(3'b101, 0, 0, 1, 0, 0, 0, 0);
        check("R5 A restored", out_a, 1'b1);

        // R8: leaving strobe mode discards a low strobe
        cyc(3'b100, 1, 0, 0, 1, 0, 0, 0);
        cyc(3'b100, 1, 0, 1, 0, 0, 0, 0);
        check("R8 A low before exit", out_a, 1'b0);
        idle(3'b000, 1);
        idle(3'b100, 1);
        check("R8 discarded", out_a, 1'b1);

        // R7: level mode follows bit
        idle(3'b110, 1);
        check("R7 level 0", out_a, 1'b0);
        idle(3'b111, 1);
        check("R7 level 1", out_b, 1'b1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] m;
            m = ctl_mode;
            if ($urandom_range(0, 99) < 3) m = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) != 0) m[2:1] = 2'b10;
            cyc(m, $urandom_range(0, 3) != 0,
                $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
                $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
                $urandom_range(0, 6) == 0, $urandom_range(0, 1) == 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule